// File: doc/BRIEF.md
# GPIO Command Unit

This block sits beside a CPU core and acts directly on 64 general-purpose pins. It holds two 64-bit registers. The output register drives `pad_out` and the output-enable register drives `pad_oe`. Each register is split into a low half (pins 0 to 31) and a high half (pins 32 to 63). A command is accepted on a one-cycle `cmd_valid` strobe. It is a write (`cmd_rd` = 0) or a read (`cmd_rd` = 1), and either a single transfer with one 32-bit operand (`cmd_dbl` = 0, operand `cmd_a`) or a double transfer with two operands (`cmd_dbl` = 1, operands `cmd_a` then `cmd_b`). A 4-bit opcode and a 4-bit selector complete the command.

One encoding covers every kind of update. Whole-mask operations act on one half or on both halves at once. Per-pin operations select a pin by index and can be conditional on a value operand. Indexed-half operations choose the half at run time. A double read returns both halves of a register, or of the synchronised pin inputs, captured on the same clock edge. Register updates appear on the pads at the clock edge that accepts the command. Read results appear on `rd_lo`/`rd_hi` at that same edge and hold until the next read.

Top module: `gpio_cmd_unit`

## Requirements
- R1: After reset, `pad_out`, `pad_oe`, `rd_lo` and `rd_hi` are all zero.
- R2: A single write with opcode 0, 1, 2 or 3 (write, XOR, OR, AND-NOT) applies `cmd_a` to one half. Selector 0 is the output low half, 1 the output high half, 4 the enable low half and 5 the enable high half. The other half and the other register are unchanged, and the result shows on the pads after the accepting edge.
- R3: A double write with opcode 0 to 3 and selector 0 (outputs) or 4 (enables) applies `cmd_a` to pins 0 to 31 and `cmd_b` to pins 32 to 63 on one edge.
- R4: A double write with opcode 4 and selector 0 or 4 takes `cmd_a` as a pin index. It sets that bit when `cmd_b` is nonzero and clears it when `cmd_b` is zero.
- R5: A single write with opcode 5, 6 or 7 and selector 0 or 4 toggles, sets or clears the one bit named by the pin index in `cmd_a`.
- R6: A double write with opcode 5, 6 or 7 does the same as R5 when `cmd_b` is nonzero. When `cmd_b` is zero it changes nothing.
- R7: A double write with opcode 8, 9, 10 or 11 and selector 0 or 4 performs write, XOR, OR or AND-NOT of `cmd_a` on the half named by `cmd_b` (0 is low, 1 is high).
- R8: An indexed write (R7) whose half index `cmd_b` is 2 or more changes no register.
- R9: A pin index uses only bits 5:0 of `cmd_a`. The upper bits have no effect.
- R10: These write commands change nothing: opcodes 12 to 15, single opcode 4, and any selector other than those named above. With `cmd_valid` low, no register changes.
- R11: A single read returns the selected half in `rd_lo` and zero in `rd_hi`. Selector 0 or 1 selects the output halves, 4 or 5 the enable halves, and 8 or 9 the synchronised input halves. A double read with selector 0, 4 or 8 returns the low half in `rd_lo` and the high half in `rd_hi`. An undefined read selector returns zeros. A read never changes the pads, and `rd_lo`/`rd_hi` change only on reads.
- R12: `pins_in` passes through two flops. A pin change made before clock edge k is returned by a read accepted at edge k+2, and reads at edges k and k+1 return the earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_dbl | input | 1 | 1 = double transfer (two operands), 0 = single |
| cmd_op | input | 4 | Opcode |
| cmd_sel | input | 4 | Register selector |
| cmd_a | input | 32 | First operand (mask, data or pin index) |
| cmd_b | input | 32 | Second operand (high-half data, value or half index) |
| pins_in | input | 64 | Asynchronous pin inputs |
| pad_out | output | 64 | Output register to the pads |
| pad_oe | output | 64 | Output-enable register to the pads |
| rd_lo | output | 32 | Read result, first word |
| rd_hi | output | 32 | Read result, second word |

## Verification
Two events can land on the same edge. A double input read can be accepted at the edge where the synchroniser takes in a new 64-bit pin pattern, and the update of one half can coincide with that of the other. The bench changes all 64 pins together in the cycle a read is issued and repeats the read on the following edges. It expects both halves to show the old pattern twice and the new pattern on the third read, never a mix of the two. Atomic double updates are judged by reading both pad vectors one cycle after the command: every bit of both halves must already show its new value.

// File: rtl/gpio_cmd_pkg.sv
package gpio_cmd_pkg;

    localparam int HALF_W = 32;
    localparam int PIN_W  = 2 * HALF_W;
    localparam int IDX_W  = $clog2(PIN_W);

    typedef enum logic [1:0] {
        K_WRITE  = 2'd0,
        K_TOGGLE = 2'd1,
        K_SET    = 2'd2,
        K_CLEAR  = 2'd3
    } mod_kind_e;

    typedef struct packed {
        logic             hit_out;
        logic             hit_oe;
        mod_kind_e        kind;
        logic [PIN_W-1:0] field;
        logic [PIN_W-1:0] data;
    } upd_t;

    typedef struct packed {
        logic [PIN_W-1:0]  out_v;
        logic [PIN_W-1:0]  oe_v;
        logic [HALF_W-1:0] rd_lo;
        logic [HALF_W-1:0] rd_hi;
    } unit_state_t;

    function automatic logic [PIN_W-1:0] apply_mod(
        input logic [PIN_W-1:0] cur,
        input mod_kind_e        kind,
        input logic [PIN_W-1:0] field,
        input logic [PIN_W-1:0] data
    );
        logic [PIN_W-1:0] eff;
        eff = data & field;
        case (kind)
            K_WRITE:  apply_mod = (cur & ~field) | eff;
            K_TOGGLE: apply_mod = cur ^ eff;
            K_SET:    apply_mod = cur | eff;
            default:  apply_mod = cur & ~eff;
        endcase
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int STAGES = 2,
    parameter int W      = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cmd_decode.sv
module gpio_cmd_decode
    import gpio_cmd_pkg::*;
(
    input  logic              valid,
    input  logic              is_rd,
    input  logic              is_dbl,
    input  logic [3:0]        op,
    input  logic [3:0]        sel,
    input  logic [HALF_W-1:0] opa,
    input  logic [HALF_W-1:0] opb,
    output upd_t              upd
);
    localparam logic [PIN_W-1:0] LO_FIELD = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    localparam logic [PIN_W-1:0] HI_FIELD = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
    localparam logic [PIN_W-1:0] ONE      = {{(PIN_W-1){1'b0}}, 1'b1};

    logic             base_ok;
    logic             b_nz;
    logic             en;
    logic             to_oe;
    logic [PIN_W-1:0] bit_field;

    always_comb begin
        base_ok   = (sel == 4'd0) || (sel == 4'd4);
        b_nz      = (opb != '0);
        bit_field = ONE << opa[IDX_W-1:0];
        en        = 1'b0;
        to_oe     = sel[2];
        upd       = '0;
        upd.kind  = mod_kind_e'(op[1:0]);

        if (valid && !is_rd) begin
            if (op <= 4'd3) begin
                if (!is_dbl) begin
                    en        = (sel[3] == 1'b0) && (sel[1] == 1'b0);
                    upd.field = sel[0] ? HI_FIELD : LO_FIELD;
                    upd.data  = {opa, opa};
                end else begin
                    en        = base_ok;
                    upd.field = '1;
                    upd.data  = {opb, opa};
                end
            end else if (op == 4'd4) begin
                en        = is_dbl && base_ok;
                upd.kind  = K_WRITE;
                upd.field = bit_field;
                upd.data  = b_nz ? '1 : '0;
            end else if (op <= 4'd7) begin
                en        = base_ok && (!is_dbl || b_nz);
                upd.field = bit_field;
                upd.data  = '1;
            end else if (op <= 4'd11) begin
                en        = is_dbl && base_ok && (opb < 32'd2);
                upd.field = opb[0] ? HI_FIELD : LO_FIELD;
                upd.data  = {opa, opa};
            end
        end

        upd.hit_out = en && !to_oe;
        upd.hit_oe  = en && to_oe;
    end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_cmd_pkg::*;
(
    input  logic              is_dbl,
    input  logic [3:0]        sel,
    input  logic [PIN_W-1:0]  out_v,
    input  logic [PIN_W-1:0]  oe_v,
    input  logic [PIN_W-1:0]  in_v,
    output logic [HALF_W-1:0] res_lo,
    output logic [HALF_W-1:0] res_hi
);
    logic [PIN_W-1:0] src;
    logic             src_ok;

    always_comb begin
        src_ok = 1'b1;
        case (sel[3:1])
            3'b000:  src = out_v;
            3'b010:  src = oe_v;
            3'b100:  src = in_v;
            default: begin
                src    = '0;
                src_ok = 1'b0;
            end
        endcase

        res_lo = '0;
        res_hi = '0;
        if (is_dbl) begin
            if (src_ok && !sel[0]) begin
                res_lo = src[HALF_W-1:0];
                res_hi = src[PIN_W-1:HALF_W];
            end
        end else if (src_ok) begin
            res_lo = sel[0] ? src[PIN_W-1:HALF_W] : src[HALF_W-1:0];
        end
    end
endmodule

// File: rtl/gpio_cmd_unit.sv
module gpio_cmd_unit
    import gpio_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_rd,
    input  logic              cmd_dbl,
    input  logic [3:0]        cmd_op,
    input  logic [3:0]        cmd_sel,
    input  logic [HALF_W-1:0] cmd_a,
    input  logic [HALF_W-1:0] cmd_b,
    input  logic [PIN_W-1:0]  pins_in,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe,
    output logic [HALF_W-1:0] rd_lo,
    output logic [HALF_W-1:0] rd_hi
);
    unit_state_t       st_d, st_q;
    upd_t              upd;
    logic [PIN_W-1:0]  pins_sync;
    logic [HALF_W-1:0] mux_lo, mux_hi;

    gpio_in_sync #(.STAGES(SYNC_STAGES), .W(PIN_W)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_in),
        .sync_out (pins_sync)
    );

    gpio_cmd_decode i_dec (
        .valid  (cmd_valid),
        .is_rd  (cmd_rd),
        .is_dbl (cmd_dbl),
        .op     (cmd_op),
        .sel    (cmd_sel),
        .opa    (cmd_a),
        .opb    (cmd_b),
        .upd    (upd)
    );

    gpio_read_mux i_rmux (
        .is_dbl (cmd_dbl),
        .sel    (cmd_sel),
        .out_v  (st_q.out_v),
        .oe_v   (st_q.oe_v),
        .in_v   (pins_sync),
        .res_lo (mux_lo),
        .res_hi (mux_hi)
    );

    always_comb begin
        st_d = st_q;
        if (upd.hit_out) st_d.out_v = apply_mod(st_q.out_v, upd.kind, upd.field, upd.data);
        if (upd.hit_oe)  st_d.oe_v  = apply_mod(st_q.oe_v,  upd.kind, upd.field, upd.data);
        if (cmd_valid && cmd_rd) begin
            st_d.rd_lo = mux_lo;
            st_d.rd_hi = mux_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pad_out = st_q.out_v;
    assign pad_oe  = st_q.oe_v;
    assign rd_lo   = st_q.rd_lo;
    assign rd_hi   = st_q.rd_hi;

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(pad_out) && $stable(pad_oe) && $stable(rd_lo) && $stable(rd_hi)));

    a_r11_read_keeps_pads: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_rd) |=> ($stable(pad_out) && $stable(pad_oe)));

    a_r11_rd_holds_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_rd) |=> ($stable(rd_lo) && $stable(rd_hi)));

    a_r5_one_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_rd && cmd_op >= 4'd4 && cmd_op <= 4'd7)
        |=> ($countones({pad_out ^ $past(pad_out), pad_oe ^ $past(pad_oe)}) <= 1));

    a_r8_bad_half_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_rd && cmd_dbl && cmd_op >= 4'd8 && cmd_op <= 4'd11 && cmd_b >= 32'd2)
        |=> ($stable(pad_out) && $stable(pad_oe)));

    a_r10_high_op_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_rd && cmd_op >= 4'd12) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

// File: tb/test_gpio_cmd_unit.sv
`timescale 1ns/1ps
module test_gpio_cmd_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_rd = 1'b0, cmd_dbl = 1'b0;
    logic [3:0]  cmd_op = '0, cmd_sel = '0;
    logic [31:0] cmd_a = '0, cmd_b = '0;
    logic [63:0] pins_in = '0;
    logic [63:0] pad_out, pad_oe;
    logic [31:0] rd_lo, rd_hi;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] exp_out = '0, exp_oe = '0, exp_rd = '0;

    always #2 clk = ~clk;

    gpio_cmd_unit i_gpio_cmd_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
        .cmd_dbl(cmd_dbl), .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_a(cmd_a),
        .cmd_b(cmd_b), .pins_in(pins_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .rd_lo(rd_lo), .rd_hi(rd_hi)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic string tag_of(input bit rd, input bit dbl, input [3:0] op,
                                     input [3:0] sel, input [31:0] b);
        if (rd) return "R11";
        if (op >= 12) return "R10";
        if (op < 4)  return dbl ? "R3" : "R2";
        if (op == 4) return dbl ? "R4" : "R10";
        if (op < 8)  return dbl ? "R6" : "R5";
        if (dbl && b >= 2) return "R8";
        return "R7";
    endfunction

    // Reference model of a write, from the requirement text.
    task automatic ref_write(input bit dbl, input [3:0] op, input [3:0] sel,
                             input [31:0] a, input [31:0] b);
        logic [63:0] r, f, d;
        bit go = 0;
        bit to_oe = 0;
        int mode;
        logic [63:0] pin_bit;
        pin_bit = 64'd1 << (a % 64);
        f = 0; d = 0; mode = op % 4;
        if (op < 4 && !dbl && (sel == 0 || sel == 1 || sel == 4 || sel == 5)) begin
            go = 1; to_oe = (sel >= 4);
            f = (sel % 2 == 1) ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
            d = {a, a};
        end else if (op < 4 && dbl && (sel == 0 || sel == 4)) begin
            go = 1; to_oe = (sel == 4); f = '1; d = {b, a};
        end else if (op == 4 && dbl && (sel == 0 || sel == 4)) begin
            go = 1; to_oe = (sel == 4); f = pin_bit; d = (b != 0) ? '1 : '0; mode = 0;
        end else if (op >= 5 && op <= 7 && (sel == 0 || sel == 4) && (!dbl || b != 0)) begin
            go = 1; to_oe = (sel == 4); f = pin_bit; d = '1;
        end else if (op >= 8 && op <= 11 && dbl && (sel == 0 || sel == 4) && b < 2) begin
            go = 1; to_oe = (sel == 4);
            f = (b == 1) ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
            d = {a, a};
        end
        if (go) begin
            r = to_oe ? exp_oe : exp_out;
            case (mode)
                0: r = (r & ~f) | (d & f);
                1: r = r ^ (d & f);
                2: r = r | (d & f);
                default: r = r & ~(d & f);
            endcase
            if (to_oe) exp_oe = r; else exp_out = r;
        end
    endtask

    function automatic logic [63:0] ref_read(input bit dbl, input [3:0] sel, input [63:0] pv);
        logic [63:0] w;
        bit ok = 1;
        case (sel)
            0, 1: w = exp_out;
            4, 5: w = exp_oe;
            8, 9: w = pv;
            default: begin w = 0; ok = 0; end
        endcase
        if (!ok) return 64'd0;
        if (dbl) return (sel % 2 == 0) ? w : 64'd0;
        return {32'd0, (sel % 2 == 1) ? w[63:32] : w[31:0]};
    endfunction

    // Drive one command for one edge, then check at the following negedge.
    task automatic issue(input bit rd, input bit dbl, input [3:0] op, input [3:0] sel,
                         input [31:0] a, input [31:0] b);
        string t;
        t = tag_of(rd, dbl, op, sel, b);
        @(negedge clk);
        cmd_valid = 1; cmd_rd = rd; cmd_dbl = dbl; cmd_op = op; cmd_sel = sel;
        cmd_a = a; cmd_b = b;
        if (rd) exp_rd = ref_read(dbl, sel, pins_in);
        else    ref_write(dbl, op, sel, a, b);
        @(negedge clk);
        cmd_valid = 0;
        chk({t, " pad_out"}, pad_out, exp_out);
        chk({t, " pad_oe"}, pad_oe, exp_oe);
        chk({t, (rd ? " read data" : " R11 read hold")}, {rd_hi, rd_lo}, exp_rd);
    endtask

    initial begin
        #(4 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] pat [4];
        pat[0] = 32'hA5A5_0F0F; pat[1] = 32'hFFFF_FFFF; pat[2] = 32'h1234_5678; pat[3] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset pads", {pad_out ^ 64'd0} | pad_oe, 64'd0);
        chk("R1 reset read", {rd_hi, rd_lo}, 64'd0);

        // R2: single mask ops on each half of each register
        for (int s = 0; s < 6; s++) begin
            if (s == 2 || s == 3) continue;
            for (int o = 0; o < 4; o++)
                for (int p = 0; p < 4; p++)
                    issue(0, 0, 4'(o), 4'(s), pat[p] ^ (32'(s) << 4), 32'hDEAD_BEEF);
        end
        // R3: double mask ops, both halves on one edge
        for (int s = 0; s <= 4; s += 4)
            for (int o = 0; o < 4; o++)
                for (int p = 0; p < 4; p++)
                    issue(0, 1, 4'(o), 4'(s), pat[p], pat[(p + 1) % 4] ^ 32'h00FF_0000);
        // R5: unconditional bit ops over every pin of both registers
        for (int s = 0; s <= 4; s += 4)
            for (int i = 0; i < 64; i++) begin
                issue(0, 0, 4'd6, 4'(s), 32'(i), 32'd0);
                issue(0, 0, 4'd5, 4'(s), 32'(63 - i), 32'd0);
                issue(0, 0, 4'd7, 4'(s), 32'((i * 7) % 64), 32'd0);
            end
        // R4 and R6: pin put and conditional bit ops
        for (int s = 0; s <= 4; s += 4)
            for (int i = 0; i < 64; i += 3) begin
                issue(0, 1, 4'd4, 4'(s), 32'(i), 32'(i % 2));
                issue(0, 1, 4'(5 + i % 3), 4'(s), 32'(i), 32'd0);
                issue(0, 1, 4'(5 + i % 3), 4'(s), 32'(63 - i), 32'h8000_0000);
            end
        // R9: garbage above the 6-bit pin index
        for (int i = 0; i < 64; i += 5) begin
            issue(0, 0, 4'd6, 4'd0, 32'hFFFF_FFC0 | 32'(i), 32'd0);
            issue(0, 1, 4'd4, 4'd4, 32'h5555_5540 | 32'(i), 32'd1);
        end
        // R7 and R8: indexed halves, including out-of-range half index
        for (int s = 0; s <= 4; s += 4)
            for (int o = 8; o < 12; o++)
                for (int h = 0; h < 4; h++)
                    issue(0, 1, 4'(o), 4'(s), pat[(o + h) % 4] ^ 32'h0F00_F00F, 32'(h == 3 ? 32'h8000_0001 : h));
        // R10 plus all: exhaustive write sweep over opcode, selector and transfer size
        for (int d = 0; d < 2; d++)
            for (int o = 0; o < 16; o++)
                for (int s = 0; s < 16; s++)
                    issue(0, d[0], 4'(o), 4'(s), 32'h9E37_79B9 * 32'(o * 16 + s + 1), 32'(s % 3));
        // R10: valid low with active-looking operands
        @(negedge clk);
        cmd_op = 4'd0; cmd_sel = 4'd0; cmd_a = 32'hFFFF_FFFF; cmd_rd = 1;
        @(negedge clk);
        chk("R10 idle pads", pad_out, exp_out);
        chk("R10 idle read", {rd_hi, rd_lo}, exp_rd);

        // R11: all read selectors, single and double
        pins_in = 64'hC3C3_1234_8765_ABCD;
        repeat (3) @(negedge clk);
        for (int d = 0; d < 2; d++)
            for (int s = 0; s < 16; s++)
                issue(1, d[0], 4'd0, 4'(s), 32'd0, 32'd0);

        // R12: two-flop latency, both halves of the input sample change together
        @(negedge clk);
        pins_in = 64'h0F1E_2D3C_4B5A_6978;
        cmd_valid = 1; cmd_rd = 1; cmd_dbl = 1; cmd_sel = 4'd8;
        @(negedge clk);
        chk("R12 read at edge k", {rd_hi, rd_lo}, 64'hC3C3_1234_8765_ABCD);
        @(negedge clk);
        chk("R12 read at edge k+1", {rd_hi, rd_lo}, 64'hC3C3_1234_8765_ABCD);
        @(negedge clk);
        chk("R12 read at edge k+2", {rd_hi, rd_lo}, 64'h0F1E_2D3C_4B5A_6978);
        cmd_valid = 0;
        exp_rd = 64'h0F1E_2D3C_4B5A_6978;
        issue(1, 0, 4'd0, 4'd9, 32'd0, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule